// File: doc/BRIEF.md
# HDMI Sink Link-State Sequencer

This block controls how a video/audio sink is brought up and when its outputs are muted or released. It watches a link-clock-detect flag, a sync-detect flag, an HDMI/DVI mode flag, an AV-mute request, three format measurements (horizontal resolution, vertical resolution and a pixel-clock count), an audio-stable flag and a format-supported flag. From these it drives a power-up enable, a video mute, an audio mute and a state code.

Work is divided into four recurring time slots. The slots rotate in a fixed order: video, audio, error handling, idle. Each slot lasts a parameterised number of clock cycles. Video stability, the audio wait, sync retries and format-change detection each advance only at the end of their own slot. Only loss of the link clock and a fresh clock detection are handled on any cycle. A new format is accepted only after it has held still for several video slots. An input in DVI mode goes straight to playback once its video is stable, because it carries no audio to wait for.

Top module: `hdmi_sink_seq`

## Requirements
- R1: After reset, state_code is 0, power_up is low, and video_mute and audio_mute are both high. The state codes are: 0 powered down, 1 waiting for sync, 2 waiting for stable video, 3 waiting for stable audio, 4 playback, 5 unsupported format.
- R2: In state 0, a rising edge of clk_det sets state_code to 1 and raises power_up on the next cycle. If clk_det stays high with no fresh rise, the block stays powered down.
- R3: Slots rotate in the order video, audio, error, idle, and each slot lasts SLOT_CYCLES cycles. In state 1, sync_det high at the end of a video slot moves the block to state 2.
- R4: At the end of every video slot, h_res, v_res and pclk_cnt are compared with their values at the end of the previous video slot. An absolute difference above 3 in any one of them is a format change. A difference of 3 or less is not.
- R5: In state 2, VID_STABLE consecutive video slots without a format change, AV-mute or sync loss, with fmt_ok and hdmi_mode high, clear video_mute and move the block to state 3. With the default VID_STABLE of 4 this takes 4 slot rotations.
- R6: A format change or av_mute high at the end of a video slot, in states 2 to 5, sets both mutes, restarts the video-stable count and moves the block to state 2.
- R7: In state 3, audio_stable high at the end of AUD_STABLE consecutive audio slots clears audio_mute and moves the block to state 4. An audio slot that ends with audio_stable low restarts the count.
- R8: With hdmi_mode low, stable and supported video moves the block from state 2 directly to state 4, with video_mute low and audio_mute still high.
- R9: With fmt_ok low, stable video moves the block to state 5 with video_mute high. It stays there until a format change occurs.
- R10: At the end of an error slot in state 4, with hdmi_mode high and audio_stable low, audio_mute is set and the block moves to state 3 while video stays unmuted. With hdmi_mode low this has no effect.
- R11: sync_det low at the end of a video slot in states 2 to 5 sets both mutes and moves the block to state 1. In state 1, SCDT_RETRY video slots without sync drop power_up and move the block to state 0.
- R12: clk_det low in any cycle moves the block to state 0 on the next cycle, with power_up low and both mutes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_det | input | 1 | Link clock detected |
| sync_det | input | 1 | Stable sync detected |
| hdmi_mode | input | 1 | 1 = HDMI input, 0 = DVI input |
| av_mute | input | 1 | Source requests audio/video mute |
| h_res | input | RES_W | Measured horizontal resolution |
| v_res | input | RES_W | Measured vertical resolution |
| pclk_cnt | input | PCLK_W | Measured pixel-clock count |
| audio_stable | input | 1 | Incoming audio is stable |
| fmt_ok | input | 1 | Incoming video format is supported |
| power_up | output | 1 | Receiver functions powered |
| video_mute | output | 1 | Video output muted |
| audio_mute | output | 1 | Audio output muted |
| state_code | output | 3 | Current state code (see R1) |

## Verification
Some properties are checked on every cycle: the response one cycle after clock loss, the link between power and the powered-down state, that video and audio are released only in the states allowed to release them, that audio is never unmuted while video is muted, and that the unsupported-format state keeps everything muted. Other behaviour only the bench's directed scenarios can show. This covers the exact slot counts before video and audio are released, the ±3 tolerance boundary on the measurements, the DVI shortcut, the error-slot audio fallback, the sync retry timeout, and the need for a fresh clock-detect edge.

// File: rtl/sink_seq_pkg.sv
// Package: shared state and slot encodings for the sink link sequencer.
// Assumes: state codes are visible at the top-level port, so their values are fixed.
package sink_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_SYNC   = 3'd1,
        ST_VIDEO  = 3'd2,
        ST_AUDIO  = 3'd3,
        ST_PLAY   = 3'd4,
        ST_BADFMT = 3'd5
    } link_st_t;

    typedef enum logic [1:0] {
        SL_VID  = 2'd0,
        SL_AUD  = 2'd1,
        SL_ERR  = 2'd2,
        SL_IDLE = 2'd3
    } slot_t;

endpackage

// File: rtl/slot_timer.sv
// Module: slot_timer
// Splits time into four rotating slots of SLOT_CYCLES cycles each.
// tick is high on the last cycle of a slot, and slot names the slot that is ending.
// Assumes: SLOT_CYCLES >= 2.
module slot_timer
    import sink_seq_pkg::*;
#(
    parameter int SLOT_CYCLES = 400000
) (
    input  logic  clk,
    input  logic  rst_n,
    output logic  tick,
    output slot_t slot
);
    localparam int CW = $clog2(SLOT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Counts cycles within a slot and advances to the next slot at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            slot <= SL_VID;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            slot <= slot_t'(slot + 2'd1);
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Marks the final cycle of the current slot.
    always_comb tick = (cnt == LAST);

endmodule

// File: rtl/fmt_compare.sv
// Module: fmt_compare
// Keeps the three format measurements taken at the previous video slot end.
// Reports a change when any current value differs from its stored value by more than TOL.
// Assumes: clear is held while no video comparison is meaningful. The first sample after clear never reports a change.
module fmt_compare #(
    parameter int RES_W  = 16,
    parameter int PCLK_W = 8,
    parameter int TOL    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [RES_W-1:0]  h_res,
    input  logic [RES_W-1:0]  v_res,
    input  logic [PCLK_W-1:0] pclk_cnt,
    output logic              changed
);
    localparam int NMEAS = 3;
    localparam int MW    = (RES_W > PCLK_W) ? RES_W : PCLK_W;

    logic [MW-1:0] cur  [NMEAS];
    logic [MW-1:0] prev [NMEAS];
    logic [NMEAS-1:0] far;
    logic valid;

    // Gathers the measurements into one zero-extended array.
    always_comb begin
        cur[0] = MW'(h_res);
        cur[1] = MW'(v_res);
        cur[2] = MW'(pclk_cnt);
    end

    for (genvar i = 0; i < NMEAS; i++) begin : g_meas
        logic [MW-1:0] diff;

        // Stores this measurement at every video slot end.
        always_ff @(posedge clk) begin
            if (!rst_n) prev[i] <= '0;
            else if (sample) prev[i] <= cur[i];
        end

        // Absolute distance from the previous sample, tested against the tolerance.
        always_comb begin
            diff   = (cur[i] >= prev[i]) ? (cur[i] - prev[i]) : (prev[i] - cur[i]);
            far[i] = (32'(diff) > TOL);
        end
    end

    // Tracks whether a previous sample exists to compare with.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) valid <= 1'b0;
        else if (sample) valid <= 1'b1;
    end

    // Flags a format change only against a valid earlier sample.
    always_comb changed = valid && (|far);

endmodule

// File: rtl/sink_fsm.sv
// Module: sink_fsm
// Link-state machine. Acts at slot ends to judge sync, video stability, audio
// stability and audio errors. Reacts on any cycle to clock loss and to a fresh clock detection.
// Assumes: tick/slot come from slot_timer, and fmt_changed is valid whenever tick is high in the video slot.
module sink_fsm
    import sink_seq_pkg::*;
#(
    parameter int VID_STABLE = 4,
    parameter int AUD_STABLE = 4,
    parameter int SCDT_RETRY = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clk_det,
    input  logic     sync_det,
    input  logic     hdmi_mode,
    input  logic     av_mute,
    input  logic     audio_stable,
    input  logic     fmt_ok,
    input  logic     tick,
    input  slot_t    slot,
    input  logic     fmt_changed,
    output link_st_t state,
    output logic     power_up,
    output logic     video_mute,
    output logic     audio_mute
);
    localparam int VW = $clog2(VID_STABLE) + 1;
    localparam int AW = $clog2(AUD_STABLE) + 1;
    localparam int RW = $clog2(SCDT_RETRY) + 1;
    localparam logic [VW-1:0] V_LAST = VW'(VID_STABLE - 1);
    localparam logic [AW-1:0] A_LAST = AW'(AUD_STABLE - 1);
    localparam logic [RW-1:0] R_LAST = RW'(SCDT_RETRY - 1);

    logic [VW-1:0] vcnt;
    logic [AW-1:0] acnt;
    logic [RW-1:0] rcnt;
    logic det_q;

    // Main sequencer: clock loss first, then power-up, then slot-end decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            power_up   <= 1'b0;
            video_mute <= 1'b1;
            audio_mute <= 1'b1;
            vcnt       <= '0;
            acnt       <= '0;
            rcnt       <= '0;
            det_q      <= 1'b0;
        end else begin
            det_q <= clk_det;
            if (!clk_det) begin
                state      <= ST_OFF;
                power_up   <= 1'b0;
                video_mute <= 1'b1;
                audio_mute <= 1'b1;
                vcnt       <= '0;
                acnt       <= '0;
                rcnt       <= '0;
            end else if (state == ST_OFF) begin
                if (!det_q) begin
                    state    <= ST_SYNC;
                    power_up <= 1'b1;
                    rcnt     <= '0;
                end
            end else if (tick) begin
                case (slot)
                    SL_VID: begin
                        if (state == ST_SYNC) begin
                            if (sync_det) begin
                                state <= ST_VIDEO;
                                vcnt  <= '0;
                            end else if (rcnt == R_LAST) begin
                                state    <= ST_OFF;
                                power_up <= 1'b0;
                            end else begin
                                rcnt <= rcnt + 1'b1;
                            end
                        end else if (!sync_det) begin
                            state      <= ST_SYNC;
                            rcnt       <= '0;
                            video_mute <= 1'b1;
                            audio_mute <= 1'b1;
                        end else if (fmt_changed || av_mute) begin
                            state      <= ST_VIDEO;
                            vcnt       <= '0;
                            video_mute <= 1'b1;
                            audio_mute <= 1'b1;
                        end else if (state == ST_VIDEO) begin
                            if (vcnt == V_LAST) begin
                                if (!fmt_ok) begin
                                    state <= ST_BADFMT;
                                end else begin
                                    video_mute <= 1'b0;
                                    if (hdmi_mode) begin
                                        state <= ST_AUDIO;
                                        acnt  <= '0;
                                    end else begin
                                        state <= ST_PLAY;
                                    end
                                end
                            end else begin
                                vcnt <= vcnt + 1'b1;
                            end
                        end
                    end
                    SL_AUD: begin
                        if (state == ST_AUDIO) begin
                            if (!audio_stable) begin
                                acnt <= '0;
                            end else if (acnt == A_LAST) begin
                                audio_mute <= 1'b0;
                                state      <= ST_PLAY;
                            end else begin
                                acnt <= acnt + 1'b1;
                            end
                        end
                    end
                    SL_ERR: begin
                        if (state == ST_PLAY && hdmi_mode && !audio_stable) begin
                            audio_mute <= 1'b1;
                            state      <= ST_AUDIO;
                            acnt       <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/hdmi_sink_seq.sv
// Module: hdmi_sink_seq (top)
// Sink bring-up and mute sequencer. Built from a slot timer, a format-change
// comparator and the link-state machine.
// Assumes: all inputs are synchronous to clk. Default SLOT_CYCLES gives 8 ms slots at 50 MHz.
module hdmi_sink_seq
    import sink_seq_pkg::*;
#(
    parameter int SLOT_CYCLES = 400000,
    parameter int RES_W       = 16,
    parameter int PCLK_W      = 8,
    parameter int TOL         = 3,
    parameter int VID_STABLE  = 4,
    parameter int AUD_STABLE  = 4,
    parameter int SCDT_RETRY  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_det,
    input  logic              sync_det,
    input  logic              hdmi_mode,
    input  logic              av_mute,
    input  logic [RES_W-1:0]  h_res,
    input  logic [RES_W-1:0]  v_res,
    input  logic [PCLK_W-1:0] pclk_cnt,
    input  logic              audio_stable,
    input  logic              fmt_ok,
    output logic              power_up,
    output logic              video_mute,
    output logic              audio_mute,
    output logic [2:0]        state_code
);
    logic     tick;
    slot_t    slot;
    logic     fmt_changed;
    logic     cmp_clear;
    link_st_t state;

    slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .slot (slot)
    );

    // Comparison is meaningless until the link has reached the video wait.
    always_comb cmp_clear = (state == ST_OFF) || (state == ST_SYNC);

    fmt_compare #(.RES_W(RES_W), .PCLK_W(PCLK_W), .TOL(TOL)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cmp_clear),
        .sample  (tick && (slot == SL_VID)),
        .h_res   (h_res),
        .v_res   (v_res),
        .pclk_cnt(pclk_cnt),
        .changed (fmt_changed)
    );

    sink_fsm #(
        .VID_STABLE(VID_STABLE),
        .AUD_STABLE(AUD_STABLE),
        .SCDT_RETRY(SCDT_RETRY)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_det     (clk_det),
        .sync_det    (sync_det),
        .hdmi_mode   (hdmi_mode),
        .av_mute     (av_mute),
        .audio_stable(audio_stable),
        .fmt_ok      (fmt_ok),
        .tick        (tick),
        .slot        (slot),
        .fmt_changed (fmt_changed),
        .state       (state),
        .power_up    (power_up),
        .video_mute  (video_mute),
        .audio_mute  (audio_mute)
    );

    // Exposes the state as its numeric code.
    always_comb state_code = 3'(state);

endmodule

// File: rtl/sink_seq_checker.sv
// Module: sink_seq_checker
// Cycle-by-cycle properties on the sequencer's ports. Attached to the top by bind.
// Assumes: synchronous active-low reset; every property is disabled during reset.
module sink_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_det,
    input logic       power_up,
    input logic       video_mute,
    input logic       audio_mute,
    input logic [2:0] state_code
);
    // R12: losing the link clock powers down and mutes on the next cycle.
    p_clk_loss_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_det |=> (state_code == 3'd0) && !power_up && video_mute && audio_mute);

    // R1: power is off exactly in the powered-down state.
    p_power_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0) |-> !power_up);
    p_off_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !power_up |-> (state_code == 3'd0));

    // R2: power comes up only on entry to the sync wait.
    p_power_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_up) |-> (state_code == 3'd1));

    // R5: video is released only into the audio wait or playback.
    p_video_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(video_mute) |-> (state_code == 3'd3) || (state_code == 3'd4));

    // R7: audio is released only into playback.
    p_audio_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(audio_mute) |-> (state_code == 3'd4));

    // R6: audio is never audible while video is muted.
    p_audio_needs_video_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !audio_mute |-> !video_mute);

    // R9: the unsupported-format state keeps both outputs muted.
    p_badfmt_muted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5) |-> video_mute && audio_mute);

    // R1: the state code never leaves its defined range.
    p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 3'd5);

endmodule

bind hdmi_sink_seq sink_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_det   (clk_det),
    .power_up  (power_up),
    .video_mute(video_mute),
    .audio_mute(audio_mute),
    .state_code(state_code)
);

// File: tb/sim_hdmi_sink_seq.sv
// Directed bench for hdmi_sink_seq. Slots are 10 cycles long, so one full rotation is 40 cycles.
module sim_hdmi_sink_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_det = 1'b0, sync_det = 1'b0, hdmi_mode = 1'b1, av_mute = 1'b0;
    logic [15:0] h_res = 16'd1280, v_res = 16'd720;
    logic [7:0]  pclk_cnt = 8'd200;
    logic        audio_stable = 1'b0, fmt_ok = 1'b1;
    logic        power_up, video_mute, audio_mute;
    logic [2:0]  state_code;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    hdmi_sink_seq #(.SLOT_CYCLES(10)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_det(clk_det), .sync_det(sync_det),
        .hdmi_mode(hdmi_mode), .av_mute(av_mute), .h_res(h_res), .v_res(v_res),
        .pclk_cnt(pclk_cnt), .audio_stable(audio_stable), .fmt_ok(fmt_ok),
        .power_up(power_up), .video_mute(video_mute), .audio_mute(audio_mute),
        .state_code(state_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_until(input int code, input int lim, output int n);
        n = 0;
        while (n < lim && state_code != 3'(code)) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk("R1 state", int'(state_code), 0);
        chk("R1 power", int'(power_up), 0);
        chk("R1 vmute", int'(video_mute), 1);
        chk("R1 amute", int'(audio_mute), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_bringup();
        int n;
        clk_det = 1'b1;
        @(negedge clk);
        chk("R2 state", int'(state_code), 1);
        chk("R2 power", int'(power_up), 1);
        sync_det = 1'b1;
        run_until(2, 60, n);
        chk("R3 sync to video", int'(state_code), 2);
    endtask

    task automatic t_hdmi_unmute();
        int n;
        run_until(3, 400, n);
        chk("R5 cycles to audio wait", n, 160);
        chk("R5 vmute", int'(video_mute), 0);
        chk("R5 amute", int'(audio_mute), 1);
        audio_stable = 1'b1;
        run_until(4, 400, n);
        chk("R7 cycles to playback", n, 130);
        chk("R7 amute", int'(audio_mute), 0);
    endtask

    task automatic t_tolerance();
        int n;
        h_res = h_res + 16'd3;
        repeat (100) @(negedge clk);
        chk("R4 diff 3 kept playback", int'(state_code), 4);
        h_res = h_res + 16'd4;
        run_until(2, 50, n);
        chk("R4 diff 4 change", int'(state_code), 2);
        chk("R6 vmute on change", int'(video_mute), 1);
        chk("R6 amute on change", int'(audio_mute), 1);
        run_until(4, 400, n);
        chk("R4 reacquire", int'(state_code), 4);
    endtask

    task automatic t_avmute();
        int n;
        av_mute = 1'b1;
        run_until(2, 50, n);
        chk("R6 avmute state", int'(state_code), 2);
        chk("R6 avmute vmute", int'(video_mute), 1);
        repeat (200) @(negedge clk);
        chk("R6 held in video wait", int'(state_code), 2);
        av_mute = 1'b0;
        run_until(4, 400, n);
        chk("R6 recover", int'(state_code), 4);
    endtask

    task automatic t_err_slot();
        int n;
        audio_stable = 1'b0;
        run_until(3, 50, n);
        chk("R10 state", int'(state_code), 3);
        chk("R10 amute", int'(audio_mute), 1);
        chk("R10 vmute", int'(video_mute), 0);
        audio_stable = 1'b1;
        run_until(4, 200, n);
        chk("R7 back to playback", int'(state_code), 4);
    endtask

    task automatic t_dvi();
        int n;
        hdmi_mode = 1'b0;
        v_res = v_res - 16'd10;
        run_until(2, 50, n);
        chk("R4 v decrease change", int'(state_code), 2);
        run_until(4, 400, n);
        chk("R8 cycles to playback", n, 160);
        chk("R8 vmute", int'(video_mute), 0);
        chk("R8 amute", int'(audio_mute), 1);
        audio_stable = 1'b0;
        repeat (100) @(negedge clk);
        chk("R10 DVI ignores audio", int'(state_code), 4);
        audio_stable = 1'b1;
    endtask

    task automatic t_badfmt();
        int n;
        fmt_ok = 1'b0;
        pclk_cnt = pclk_cnt + 8'd5;
        run_until(2, 50, n);
        run_until(5, 400, n);
        chk("R9 state", int'(state_code), 5);
        chk("R9 vmute", int'(video_mute), 1);
        repeat (200) @(negedge clk);
        chk("R9 stays", int'(state_code), 5);
        fmt_ok = 1'b1;
        h_res = h_res + 16'd100;
        run_until(2, 50, n);
        run_until(4, 400, n);
        chk("R9 leaves on change", int'(state_code), 4);
    endtask

    task automatic t_sync_loss();
        int n;
        sync_det = 1'b0;
        run_until(1, 50, n);
        chk("R11 sync wait", int'(state_code), 1);
        chk("R11 vmute", int'(video_mute), 1);
        run_until(0, 800, n);
        chk("R11 retry cycles", n, 640);
        chk("R11 power", int'(power_up), 0);
        repeat (50) @(negedge clk);
        chk("R2 no edge stays off", int'(state_code), 0);
        clk_det = 1'b0;
        @(negedge clk);
        clk_det = 1'b1;
        @(negedge clk);
        chk("R2 fresh edge", int'(state_code), 1);
    endtask

    task automatic t_clk_loss();
        int n;
        sync_det = 1'b1;
        run_until(2, 60, n);
        repeat (7) @(negedge clk);
        clk_det = 1'b0;
        @(negedge clk);
        chk("R12 state", int'(state_code), 0);
        chk("R12 power", int'(power_up), 0);
        chk("R12 mutes", int'(video_mute & audio_mute), 1);
    endtask

    initial begin
        t_reset();
        t_bringup();
        t_hdmi_unmute();
        t_tolerance();
        t_avmute();
        t_err_slot();
        t_dvi();
        t_badfmt();
        t_sync_loss();
        t_clk_loss();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule